// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of 28 general-purpose input pins and turns selected transitions on them into interrupt requests. Every pin is first brought into the local clock domain by a two-flop synchroniser. An edge is then found by comparing the synchronised level with its level one cycle earlier. Each pin has its own rising-edge enable and falling-edge enable, so a pin can report rising edges, falling edges, both, or nothing. An enabled edge sets that pin's bit in a sticky event register. The bit stays set until software clears it by writing a one to it.

The eleven low pins (0 to 10) each drive a dedicated request line that follows their event bit. The seventeen high pins (11 to 27) share one request line, which is the OR of their event bits. Software uses a small word-wide register port to program the enables, read the events and clear them. Writes take effect at the next clock edge. Reads are combinational from the current register state.

Register map (word address on `reg_addr`):
- 0: rising-edge enables, bit n = pin n.
- 1: falling-edge enables, bit n = pin n.
- 2: event register. Reads return the pending events. Writing a one clears that bit.
- 3: unused. Reads return zero and writes are dropped.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, both enable registers, the event register, all of `irq_low` and `irq_high` are zero, and pin activity sets no event until an enable is written.
- R2: With bit n of the rising-edge enable (address 0) set, a 0-to-1 change on `pin_in[n]` sets event bit n. The change is applied before clock edge k, and the bit is readable after clock edge k+2.
- R3: With bit n of the falling-edge enable (address 1) set, a 1-to-0 change on `pin_in[n]` sets event bit n, with the same three-edge latency as R2.
- R4: With both enables set for a pin, either direction of change sets its event bit. With neither set, no change does.
- R5: A write to address 2 clears exactly the event bits written as one. Bits written as zero keep their value.
- R6: Writing all ones to address 2 clears every pending event in one write.
- R7: `irq_low[i]` equals event bit i for i = 0 to 10.
- R8: `irq_high` is high exactly when any of event bits 11 to 27 is set.
- R9: Clearing both enables of a pin leaves its already set event bit in place, and later edges on that pin set nothing.
- R10: When an enabled edge on pin n is detected in the same cycle as a write of one to event bit n, the bit ends up set.
- R11: Bits 31 to 28 of every register read as zero, and writing ones to them changes nothing.
- R12: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 28 | Asynchronous general-purpose input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_low | output | 11 | Per-pin requests for pins 0 to 10 |
| irq_high | output | 1 | Shared request for pins 11 to 27 |

## Verification
A pin change applied before clock edge k crosses two synchroniser flops and the previous-level flop. Its event bit and request outputs are due just after edge k+2. A register write applied before edge k is visible on the read port and on the requests just after edge k. The bench drives all inputs on the falling clock edge and keeps a cycle-accurate expected model, which it advances on each rising edge using the values it drove. It compares the read data and both request outputs at the following falling edge, so every check lands in the cycle its result is due. Directed cases place an edge and its clearing write in the same cycle, and probe the upper read bits and the unused address.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Register word addresses; software depends on this map
    typedef enum logic [1:0] {
        SEL_RISE_EN = 2'd0,
        SEL_FALL_EN = 2'd1,
        SEL_EVENTS  = 2'd2,
        SEL_UNUSED  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.stable;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] prev_d, prev_q;
    logic [WIDTH-1:0] rise_seen, fall_seen;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    // Per-pin comparison against last cycle's level
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        always_comb begin
            rise_seen[p] = level[p] & ~prev_q[p];
            fall_seen[p] = ~level[p] & prev_q[p];
            hit[p]       = (rise_seen[p] & rise_en[p]) | (fall_seen[p] & fall_en[p]);
        end
    end

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] pending
);

    logic [WIDTH-1:0] pend_d, pend_q;

    // A new event wins over a clear of the same bit
    always_comb begin
        pend_d = (pend_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS   = 28,
    parameter int N_DIRECT = 11,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_PINS-1:0]   pin_in,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic [N_DIRECT-1:0] irq_low,
    output logic                irq_high
);

    localparam int N_SHARED = N_PINS - N_DIRECT;
    localparam int PAD_W    = DW - N_PINS;

    typedef struct packed {
        logic [N_PINS-1:0] rise;
        logic [N_PINS-1:0] fall;
    } enables_t;

    enables_t          en_d, en_q;
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] clear_mask;
    logic [N_PINS-1:0] events;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_addr);

    gpio_edge_sync #(.WIDTH(N_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_edge_detect #(.WIDTH(N_PINS)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .level   (pin_sync),
        .rise_en (en_q.rise),
        .fall_en (en_q.fall),
        .hit     (edge_hit)
    );

    gpio_edge_status #(.WIDTH(N_PINS)) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (edge_hit),
        .clr_vec (clear_mask),
        .pending (events)
    );

    // Register writes; bits above the pin count are dropped
    always_comb begin
        en_d       = en_q;
        clear_mask = '0;
        if (reg_wr) begin
            case (sel)
                SEL_RISE_EN: en_d.rise  = reg_wdata[N_PINS-1:0];
                SEL_FALL_EN: en_d.fall  = reg_wdata[N_PINS-1:0];
                SEL_EVENTS:  clear_mask = reg_wdata[N_PINS-1:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    // Read mux, zero-extended to the bus width
    always_comb begin
        case (sel)
            SEL_RISE_EN: reg_rdata = {{PAD_W{1'b0}}, en_q.rise};
            SEL_FALL_EN: reg_rdata = {{PAD_W{1'b0}}, en_q.fall};
            SEL_EVENTS:  reg_rdata = {{PAD_W{1'b0}}, events};
            default:     reg_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < N_DIRECT; i++) begin : g_direct
        assign irq_low[i] = events[i];
    end

    assign irq_high = |events[N_PINS-1 -: N_SHARED];

endmodule

module gpio_edge_irq_chk #(
    parameter int N_PINS   = 28,
    parameter int N_DIRECT = 11,
    parameter int DW       = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [N_PINS-1:0] events,
    input logic [N_PINS-1:0] edge_hit,
    input logic [N_PINS-1:0] clear_mask,
    input logic [N_PINS-1:0] rise_q,
    input logic [N_PINS-1:0] fall_q,
    input logic [DW-1:0]     reg_rdata,
    input logic              irq_high
);

    // R1
    new_event_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (events & ~$past(events) & ~$past(rise_q | fall_q)) == '0);

    // R5
    cleared_bit_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (events & $past(clear_mask) & ~$past(edge_hit)) == '0);

    // R9
    event_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(events) & ~$past(clear_mask) & ~events) == '0);

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(edge_hit) & ~events) == '0);

    // R11
    upper_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DW-1:N_PINS] == '0);

    // R8
    shared_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_high) |-> ($past(edge_hit[N_PINS-1:N_DIRECT]) != '0));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .N_PINS(N_PINS), .N_DIRECT(N_DIRECT), .DW(DW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .events     (events),
    .edge_hit   (edge_hit),
    .clear_mask (clear_mask),
    .rise_q     (en_q.rise),
    .fall_q     (en_q.fall),
    .reg_rdata  (reg_rdata),
    .irq_high   (irq_high)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;

    localparam int NP = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] irq_low;
    logic        irq_high;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk(clk), .rst(rst), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_low(irq_low), .irq_high(irq_high)
    );

    // Expected model built from the requirements: three-edge pin latency,
    // write-one-to-clear, new event beats clear, 28 implemented bits.
    logic [NP-1:0] m_s1, m_s2, m_prev, m_rise, m_fall, m_ev;

    function automatic logic [NP-1:0] model_hits(logic [NP-1:0] lv, logic [NP-1:0] pv,
                                                 logic [NP-1:0] re, logic [NP-1:0] fe);
        return ((lv & ~pv) & re) | ((~lv & pv) & fe);
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_rise};
            2'd1: return {4'b0, m_fall};
            2'd2: return {4'b0, m_ev};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [NP-1:0] hits, clr;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_rise = '0; m_fall = '0; m_ev = '0;
        end else begin
            hits = model_hits(m_s2, m_prev, m_rise, m_fall);
            clr  = (reg_wr && reg_addr == 2'd2) ? reg_wdata[NP-1:0] : '0;
            m_ev = (m_ev & ~clr) | hits;
            if (reg_wr && reg_addr == 2'd0) m_rise = reg_wdata[NP-1:0];
            if (reg_wr && reg_addr == 2'd1) m_fall = reg_wdata[NP-1:0];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: outputs compared with the model
    task automatic check_outputs(string tag);
        check({tag, " R7 irq_low"}, {21'b0, irq_low}, {21'b0, m_ev[10:0]});
        check({tag, " R8 irq_high"}, {31'b0, irq_high}, {31'b0, |m_ev[27:11]});
        check({tag, " read"}, reg_rdata, model_read(reg_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        // R1 reset state
        rd_check("R1 rise_en reset", 2'd0, 32'd0);
        rd_check("R1 fall_en reset", 2'd1, 32'd0);
        rd_check("R1 events reset", 2'd2, 32'd0);
        check("R1 irq_low reset", {21'b0, irq_low}, 32'd0);
        check("R1 irq_high reset", {31'b0, irq_high}, 32'd0);
        pin_in = 28'hFFF_FFFF; repeat (4) tick();
        pin_in = '0; repeat (4) tick();
        rd_check("R1 no events without enable", 2'd2, 32'd0);

        // R2 rising edge on pin 3, due after the third edge
        wr(2'd0, 32'h0000_0008);
        pin_in[3] = 1'b1;
        tick(); tick();
        rd_check("R2 not yet after two edges", 2'd2, 32'd0);
        tick();
        rd_check("R2 rising sets bit 3", 2'd2, 32'h0000_0008);
        check("R7 irq_low bit 3", {21'b0, irq_low}, 32'h0000_0008);
        pin_in[3] = 1'b0; repeat (4) tick();
        rd_check("R2 falling ignored with rise only", 2'd2, 32'h0000_0008);
        wr(2'd2, 32'h0000_0008);
        rd_check("R5 bit 3 cleared", 2'd2, 32'd0);

        // R3 falling edge on pin 20 feeds the shared line
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h0010_0000);
        pin_in[20] = 1'b1; repeat (4) tick();
        rd_check("R3 rise ignored with fall only", 2'd2, 32'd0);
        pin_in[20] = 1'b0; repeat (3) tick();
        rd_check("R3 falling sets bit 20", 2'd2, 32'h0010_0000);
        check("R8 irq_high on bit 20", {31'b0, irq_high}, 32'd1);

        // R4 both edges on pin 0 and pin 27
        wr(2'd0, 32'h0800_0001);
        wr(2'd1, 32'h0810_0001);
        pin_in[0] = 1'b1; repeat (4) tick();
        rd_check("R4 rise on pin 0", 2'd2, 32'h0010_0001);
        pin_in[27] = 1'b1; repeat (4) tick();
        wr(2'd2, 32'h0800_0001);
        pin_in[0] = 1'b0; repeat (4) tick();
        rd_check("R4 fall on pin 0 after clear", 2'd2, 32'h0010_0001);

        // R5 zero bits keep their value
        wr(2'd2, 32'h0000_0000);
        rd_check("R5 zero write no effect", 2'd2, 32'h0010_0001);
        wr(2'd2, 32'h0000_0001);
        rd_check("R5 only bit 0 cleared", 2'd2, 32'h0010_0000);
        check("R8 irq_high still high", {31'b0, irq_high}, 32'd1);

        // R9 disabling keeps the latched bit, later edges ignored
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        pin_in[27] = 1'b0; pin_in[20] = 1'b1; repeat (4) tick();
        rd_check("R9 latched bit kept", 2'd2, 32'h0010_0000);

        // R6 clear all
        wr(2'd2, 32'hFFFF_FFFF);
        rd_check("R6 all cleared", 2'd2, 32'd0);
        check("R8 irq_high low after clear", {31'b0, irq_high}, 32'd0);

        // R10 edge and clear of the same bit in the same cycle
        wr(2'd0, 32'h0000_0400);
        pin_in[10] = 1'b1; repeat (4) tick();
        pin_in[10] = 1'b0;
        wr(2'd1, 32'h0000_0400);
        pin_in[10] = 1'b1;
        tick();
        // edge is detected at the second following edge: clear lands on it
        wr(2'd2, 32'h0000_0400);
        rd_check("R10 new event survives clear", 2'd2, 32'h0000_0400);
        check("R7 irq_low bit 10", {21'b0, irq_low}, 32'h0000_0400);
        wr(2'd2, 32'hFFFF_FFFF);

        // R11 upper bits and R12 unused address
        wr(2'd0, 32'hF000_0000);
        rd_check("R11 rise upper bits", 2'd0, 32'd0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_check("R11 fall upper bits", 2'd1, 32'h0FFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd_check("R12 unused reads zero", 2'd3, 32'd0);
        rd_check("R12 rise untouched", 2'd0, 32'd0);
        rd_check("R12 fall untouched", 2'd1, 32'h0FFF_FFFF);
        wr(2'd1, 32'd0);

        // Random mix checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            reg_wr = 1'b0;
            if (r == 0) begin
                reg_wr = 1'b1; reg_addr = 2'($urandom_range(0, 3)); reg_wdata = $urandom;
            end else begin
                reg_addr = 2'($urandom_range(0, 3));
            end
            if (r > 5) pin_in = pin_in ^ (NP'($urandom) & NP'($urandom));
            #1;
            check_outputs("random R2 R3 R4 R5");
            @(posedge clk);
            @(negedge clk);
        end
        reg_wr = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule